// File: doc/BRIEF.md
# Character LCD Command Decoder and Address Counter

This block sits behind the host bus of a character LCD controller. Every bus command brings two register-select bits, a read/write bit and a data byte. The block picks out three commands: set a character-generator (CG) RAM address, set a display-data (DD) RAM address, and write a data byte. It keeps one address counter, which is shared by all the RAMs. It also keeps a selector that records which RAM the most recent address-set command chose.

A data write produces a registered one-cycle write strobe. The strobe carries the selected RAM, the counter value from before the step, and the byte. After the write, the counter moves one step in the direction given by the entry-mode input. Display-RAM stepping follows the address windows of the current line mode: in 1-line mode there is one window, and in 2-line mode there are two windows with a jump between them. Character-generator stepping wraps modulo 64.

Each accepted command holds a busy flag for a parameterised number of oscillator cycles. Commands that arrive while the flag is set are dropped. The block also turns the line configuration into the number of common lines that the scan logic must drive.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: A command with `cmd_rs`=2'b10, `cmd_rw`=0 and `cmd_data[7:6]`=2'b01 loads `addr_cnt` with {0, `cmd_data[5:0]`} and sets `addr_sel` to 1 (CG RAM) one cycle later.
- R2: A command with `cmd_rs`=2'b10, `cmd_rw`=0 and `cmd_data[7]`=1 loads `addr_cnt` with `cmd_data[6:0]` and sets `addr_sel` to 0 (DD RAM) one cycle later.
- R3: A command with `cmd_rs`=2'b11 and `cmd_rw`=0 raises `ram_we` for exactly the next cycle. In that cycle `ram_sel` equals `addr_sel`, `ram_addr` equals the counter value before the step, and `ram_wdata` equals the byte. The selection holds until another address-set command changes it.
- R4: After a write, the counter steps up when `step_up`=1 and down when `step_up`=0. In CG RAM it wraps modulo 64, so bit 6 stays 0.
- R5: When `line_cfg[1]`=0 (1-line mode), a valid DD address steps within 0x00..0x4F and wraps between 0x4F and 0x00 in both directions.
- R6: When `line_cfg[1]`=1 (2-line mode), stepping up goes from 0x27 to 0x40 and from 0x67 to 0x00. Stepping down goes from 0x40 to 0x27 and from 0x00 to 0x67.
- R7: `busy` rises in the cycle after an accepted command and stays high for exactly BUSY_CYCLES cycles.
- R8: Commands that arrive while `busy` is high are ignored. So are commands with `cmd_rw`=1 and commands with any other code. An ignored command changes no output and does not start `busy`.
- R9: `addr_bad` is set by a DD address-set whose address lies outside the windows of the current mode, and cleared by any other address-set. A DD address outside the windows steps by plain ±1 modulo 128.
- R10: `com_lines` is 8, 9, 16 or 17 for `line_cfg` values 0, 1, 2 and 3.
- R11: After reset, `busy`, `ram_we`, `addr_bad`, `addr_cnt` and `addr_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A bus command is present this cycle |
| cmd_rs | input | 2 | Register-select bits |
| cmd_rw | input | 1 | 1 = read, 0 = write |
| cmd_data | input | 8 | Command or data byte |
| line_cfg | input | 2 | Bit 1 = 2-line mode, bit 0 = extended common count |
| step_up | input | 1 | Entry direction: 1 = increment, 0 = decrement |
| busy | output | 1 | Command in progress |
| ram_we | output | 1 | One-cycle write strobe |
| ram_sel | output | 2 | Target RAM of the write (0 = DD, 1 = CG) |
| ram_addr | output | 7 | Write address |
| ram_wdata | output | 8 | Write data |
| addr_cnt | output | 7 | Current address counter |
| addr_sel | output | 2 | RAM selected by the last address-set |
| addr_bad | output | 1 | Last DD address lies outside the windows |
| com_lines | output | 5 | Number of common lines |

## Verification
The bench builds the block with BUSY_CYCLES=4. With that value, commands can be issued back to back many times within a short run, and commands can be hit both during the busy window and right at its last cycle. The window wrap points in both line modes, the CG wrap and out-of-window stepping are driven in directed sequences. A long pseudo-random command stream then follows, and an independent list-based model compares every output on every clock.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    typedef enum logic [1:0] {
        RAM_DD = 2'd0,
        RAM_CG = 2'd1,
        RAM_AB = 2'd2
    } ram_sel_e;

    localparam int          ADDR_W      = 7;
    localparam logic [6:0]  ONE_LAST    = 7'h4F;
    localparam logic [6:0]  TWO_END_A   = 7'h27;
    localparam logic [6:0]  TWO_START_B = 7'h40;
    localparam logic [6:0]  TWO_LAST    = 7'h67;

    function automatic logic ddr_addr_ok(input logic [6:0] a, input logic two_line);
        if (two_line)
            return (a <= TWO_END_A) || ((a >= TWO_START_B) && (a <= TWO_LAST));
        else
            return a <= ONE_LAST;
    endfunction

endpackage

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
    parameter int CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R8: the decoder never accepts a command while the timer runs
    p_start_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R7: the flag drops once the last cycle has run out
    p_busy_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(1) && !start_i) |=> !busy_o);

endmodule

// File: rtl/lcd_addr_step.sv
module lcd_addr_step
    import lcd_cmd_pkg::*;
(
    input  logic [6:0] addr_i,
    input  ram_sel_e   sel_i,
    input  logic       two_line_i,
    input  logic       up_i,
    input  logic       in_window_i,
    output logic [6:0] addr_o
);
    always_comb begin
        if (sel_i == RAM_CG) begin
            addr_o = {1'b0, up_i ? (addr_i[5:0] + 6'd1) : (addr_i[5:0] - 6'd1)};
        end else if (!in_window_i) begin
            addr_o = up_i ? (addr_i + 7'd1) : (addr_i - 7'd1);
        end else if (two_line_i) begin
            if (up_i)
                addr_o = (addr_i == TWO_END_A) ? TWO_START_B :
                         (addr_i == TWO_LAST)  ? 7'h00 : addr_i + 7'd1;
            else
                addr_o = (addr_i == TWO_START_B) ? TWO_END_A :
                         (addr_i == 7'h00)       ? TWO_LAST : addr_i - 7'd1;
        end else begin
            if (up_i)
                addr_o = (addr_i == ONE_LAST) ? 7'h00 : addr_i + 7'd1;
            else
                addr_o = (addr_i == 7'h00) ? ONE_LAST : addr_i - 7'd1;
        end
    end
endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_rs,
    input  logic       cmd_rw,
    input  logic [7:0] cmd_data,
    input  logic [1:0] line_cfg,
    input  logic       step_up,
    output logic       busy,
    output logic       ram_we,
    output logic [1:0] ram_sel,
    output logic [6:0] ram_addr,
    output logic [7:0] ram_wdata,
    output logic [6:0] addr_cnt,
    output logic [1:0] addr_sel,
    output logic       addr_bad,
    output logic [4:0] com_lines
);
    typedef struct packed {
        logic [6:0] addr;
        ram_sel_e   sel;
        logic       bad;
        logic       we;
        ram_sel_e   wsel;
        logic [6:0] waddr;
        logic [7:0] wdata;
    } state_t;

    state_t st_d, st_q;

    logic       two_line;
    logic       is_cg, is_dd, is_wr, accept;
    logic [6:0] step_addr;

    assign two_line = line_cfg[1];
    assign is_cg  = (cmd_rs == 2'b10) && !cmd_rw && (cmd_data[7:6] == 2'b01);
    assign is_dd  = (cmd_rs == 2'b10) && !cmd_rw && cmd_data[7];
    assign is_wr  = (cmd_rs == 2'b11) && !cmd_rw;
    assign accept = cmd_valid && !busy && (is_cg || is_dd || is_wr);

    lcd_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .busy_o  (busy)
    );

    lcd_addr_step u_step (
        .addr_i      (st_q.addr),
        .sel_i       (st_q.sel),
        .two_line_i  (two_line),
        .up_i        (step_up),
        .in_window_i (ddr_addr_ok(st_q.addr, two_line)),
        .addr_o      (step_addr)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (accept) begin
            if (is_dd) begin
                st_d.addr = cmd_data[6:0];
                st_d.sel  = RAM_DD;
                st_d.bad  = !ddr_addr_ok(cmd_data[6:0], two_line);
            end else if (is_cg) begin
                st_d.addr = {1'b0, cmd_data[5:0]};
                st_d.sel  = RAM_CG;
                st_d.bad  = 1'b0;
            end else begin
                st_d.we    = 1'b1;
                st_d.wsel  = st_q.sel;
                st_d.waddr = st_q.addr;
                st_d.wdata = cmd_data;
                st_d.addr  = step_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (line_cfg)
            2'b00:   com_lines = 5'd8;
            2'b01:   com_lines = 5'd9;
            2'b10:   com_lines = 5'd16;
            default: com_lines = 5'd17;
        endcase
    end

    assign ram_we    = st_q.we;
    assign ram_sel   = st_q.wsel;
    assign ram_addr  = st_q.waddr;
    assign ram_wdata = st_q.wdata;
    assign addr_cnt  = st_q.addr;
    assign addr_sel  = st_q.sel;
    assign addr_bad  = st_q.bad;

    // R7: every accepted command starts the busy window
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R3: the write strobe lasts a single cycle
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R8: a command during busy leaves counter, selection and strobe untouched
    p_ignored_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> (!ram_we && $stable(addr_cnt) && $stable(addr_sel)));

    // R4: the CG counter never leaves its 64-entry space
    p_cg_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_sel == 2'd1) |-> (addr_cnt[6] == 1'b0));

endmodule

// File: tb/lcd_cmd_decoder_tb.sv
module lcd_cmd_decoder_tb_top;
    localparam int BC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_rs = 2'b00;
    logic       cmd_rw = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic [1:0] line_cfg = 2'b11;
    logic       step_up = 1'b1;
    logic       busy, ram_we, addr_bad;
    logic [1:0] ram_sel, addr_sel;
    logic [6:0] ram_addr, addr_cnt;
    logic [7:0] ram_wdata;
    logic [4:0] com_lines;

    int total = 0;
    int fails = 0;

    lcd_cmd_decoder #(.BUSY_CYCLES(BC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rs(cmd_rs),
        .cmd_rw(cmd_rw), .cmd_data(cmd_data), .line_cfg(line_cfg), .step_up(step_up),
        .busy(busy), .ram_we(ram_we), .ram_sel(ram_sel), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .addr_cnt(addr_cnt), .addr_sel(addr_sel),
        .addr_bad(addr_bad), .com_lines(com_lines)
    );

    always #2 clk = ~clk;

    // reference model state
    int m_addr = 0, m_sel = 0, m_bad = 0, m_we = 0, m_wsel = 0, m_waddr = 0, m_wdata = 0, m_cnt = 0;

    function automatic int win_index(int a, bit two);
        int lst[$];
        if (two) begin
            for (int i = 0; i <= 'h27; i++) lst.push_back(i);
            for (int i = 'h40; i <= 'h67; i++) lst.push_back(i);
        end else begin
            for (int i = 0; i <= 'h4F; i++) lst.push_back(i);
        end
        foreach (lst[i]) if (lst[i] == a) return i;
        return -1;
    endfunction

    function automatic int ref_next(int a, int sel, bit two, bit up);
        int idx, n, base;
        if (sel == 1) return up ? (a + 1) % 64 : (a + 63) % 64;
        idx = win_index(a, two);
        if (idx < 0) return up ? (a + 1) % 128 : (a + 127) % 128;
        n = two ? 80 : 80;
        idx = up ? (idx + 1) % n : (idx + n - 1) % n;
        base = (two && idx >= 40) ? ('h40 - 40) : 0;
        return idx + base;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr = 0; m_sel = 0; m_bad = 0; m_we = 0; m_cnt = 0;
            m_wsel = 0; m_waddr = 0; m_wdata = 0;
        end else begin
            bit acc;
            int kind; // 1 dd, 2 cg, 3 write
            kind = 0;
            if (cmd_valid && !cmd_rw && cmd_rs == 2'b10 && cmd_data[7]) kind = 1;
            else if (cmd_valid && !cmd_rw && cmd_rs == 2'b10 && cmd_data[7:6] == 2'b01) kind = 2;
            else if (cmd_valid && !cmd_rw && cmd_rs == 2'b11) kind = 3;
            acc = (kind != 0) && (m_cnt == 0);
            m_we = 0;
            if (m_cnt > 0) m_cnt--;
            if (acc) begin
                m_cnt = BC;
                if (kind == 1) begin
                    m_addr = int'(cmd_data[6:0]); m_sel = 0;
                    m_bad = (win_index(m_addr, line_cfg[1]) < 0) ? 1 : 0;
                end else if (kind == 2) begin
                    m_addr = int'(cmd_data[5:0]); m_sel = 1; m_bad = 0;
                end else begin
                    m_we = 1; m_wsel = m_sel; m_waddr = m_addr; m_wdata = int'(cmd_data);
                    m_addr = ref_next(m_addr, m_sel, line_cfg[1], step_up);
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        chk("R7 R8 busy", int'(busy), (m_cnt != 0) ? 1 : 0);
        chk("R3 R8 ram_we", int'(ram_we), m_we);
        if (m_we != 0) begin
            chk("R3 ram_sel", int'(ram_sel), m_wsel);
            chk("R3 ram_addr", int'(ram_addr), m_waddr);
            chk("R3 ram_wdata", int'(ram_wdata), m_wdata);
        end
        chk("R1 R2 R4 R5 R6 addr_cnt", int'(addr_cnt), m_addr);
        chk("R1 R2 addr_sel", int'(addr_sel), m_sel);
        chk("R9 addr_bad", int'(addr_bad), m_bad);
        chk("R10 com_lines", int'(com_lines), (line_cfg[1] ? 16 : 8) + int'(line_cfg[0]));
    end

    task automatic send(logic [1:0] rs, logic rw, logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_rs = rs; cmd_rw = rw; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic sendw(logic [1:0] rs, logic rw, logic [7:0] d);
        send(rs, rw, d);
        repeat (BC) @(negedge clk);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 ram_we", int'(ram_we), 0);
        chk("R11 addr_bad", int'(addr_bad), 0);
        chk("R11 addr_cnt", int'(addr_cnt), 0);
        chk("R11 addr_sel", int'(addr_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 two-line window crossing
        line_cfg = 2'b11; step_up = 1'b1;
        sendw(2'b10, 1'b0, 8'h80 | 8'h26);
        repeat (3) sendw(2'b11, 1'b0, 8'h41);
        chk("R6 jump up", int'(addr_cnt), 'h41);
        sendw(2'b10, 1'b0, 8'h80 | 8'h67);
        sendw(2'b11, 1'b0, 8'h42);
        chk("R6 wrap up", int'(addr_cnt), 'h00);
        step_up = 1'b0;
        sendw(2'b11, 1'b0, 8'h43);
        chk("R6 wrap down", int'(addr_cnt), 'h67);
        sendw(2'b10, 1'b0, 8'h80 | 8'h40);
        sendw(2'b11, 1'b0, 8'h44);
        chk("R6 jump down", int'(addr_cnt), 'h27);

        // R5 one-line wrap
        line_cfg = 2'b00; step_up = 1'b1;
        sendw(2'b10, 1'b0, 8'h80 | 8'h4F);
        sendw(2'b11, 1'b0, 8'h45);
        chk("R5 wrap up", int'(addr_cnt), 'h00);
        step_up = 1'b0;
        sendw(2'b11, 1'b0, 8'h46);
        chk("R5 wrap down", int'(addr_cnt), 'h4F);

        // R9 out-of-window addresses
        sendw(2'b10, 1'b0, 8'h80 | 8'h50);
        chk("R9 flag 1-line", int'(addr_bad), 1);
        sendw(2'b11, 1'b0, 8'h47);
        line_cfg = 2'b10; step_up = 1'b1;
        sendw(2'b10, 1'b0, 8'h80 | 8'h30);
        sendw(2'b11, 1'b0, 8'h48);
        chk("R9 plain step", int'(addr_cnt), 'h31);

        // R1 R4 CG wrap and persistent selection
        sendw(2'b10, 1'b0, 8'h40 | 8'h3F);
        chk("R9 cleared by CG set", int'(addr_bad), 0);
        sendw(2'b11, 1'b0, 8'h49);
        chk("R4 cg wrap up", int'(addr_cnt), 'h00);
        step_up = 1'b0;
        sendw(2'b11, 1'b0, 8'h4A);
        chk("R4 cg wrap down", int'(addr_cnt), 'h3F);
        chk("R3 selection held", int'(addr_sel), 1);

        // R8 busy and ignored codes
        send(2'b10, 1'b0, 8'h80 | 8'h10);
        send(2'b11, 1'b0, 8'h55);
        repeat (BC) @(negedge clk);
        chk("R8 write dropped", int'(addr_cnt), 'h10);
        send(2'b11, 1'b1, 8'h66);
        send(2'b00, 1'b0, 8'h01);
        send(2'b10, 1'b0, 8'h20);
        chk("R8 no busy", int'(busy), 0);

        // R10 all line configurations
        for (int c = 0; c < 4; c++) begin
            line_cfg = 2'(c);
            @(negedge clk);
        end

        // mixed stream
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cmd_valid = ($urandom_range(0, 2) != 0);
            cmd_rs    = 2'($urandom_range(0, 3));
            cmd_rw    = ($urandom_range(0, 7) == 0);
            cmd_data  = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 63) == 0) line_cfg = 2'($urandom_range(0, 3));
            step_up   = 1'($urandom_range(0, 1));
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (BC + 2) @(negedge clk);
        report();
    end
endmodule